// File: doc/BRIEF.md
# Boot Configuration Word Fetcher

After reset is released, this block reads a fixed series of single bytes from a boot memory through a request/acknowledge port, one read in flight at a time. It packs the bytes into eight 32-bit configuration words. The first word configures the local master. The remaining seven are held for slave devices that sit on the same bus. Every read address is a multiple of eight. Only the lowest byte lane of the data bus is sampled, so the width of the boot device's port does not matter.

When the last byte is in, the block raises a one-cycle completion flag. All words then stay frozen until the next reset. One bit of the master word picks the base of the exception vector area: either the bottom of the address space or the top megabyte. The reset vector is that base plus 0x100.

Top module: `boot_cfg_fetch`

## Requirements
- R1: Exactly 32 reads are issued after reset. Once the 32nd acknowledge is taken, `memReq` stays low until the next reset.
- R2: Read n (n = 0..31) is issued at `memAddr` = 8*n, so the first read is at address 0 and each later read is 8 above the previous one.
- R3: Only `memData[7:0]` is captured. Bits `memData[63:8]` have no effect on any output.
- R4: Reads 0..3 form `masterWord`. Reads 4k..4k+3, for k = 1..7, form slave word k, which appears on `slaveWords[32*(k-1) +: 32]`.
- R5: Within a group of four reads, the first byte lands in bits [31:24], the second in [23:16], the third in [15:8] and the fourth in [7:0].
- R6: The prefix bit is bit 15 counted from the MSB of `masterWord`, which is `masterWord[16]`. `vectorBase` is 0x00000000 when this bit is 0 and 0xFFF00000 when it is 1. `resetVector` equals `vectorBase` + 0x100.
- R7: `done` is high for exactly one cycle: the cycle after the clock edge that captures the 32nd byte. From that edge on, every word output holds its value until reset, and further acknowledges have no effect.
- R8: A raised `memReq` stays high, with `memAddr` unchanged, until `memAck` is sampled high. An acknowledge sampled while `memReq` is low is ignored.
- R9: While the synchronous active-high reset `rst` is asserted, all words and `done` are cleared. In the first cycle after `rst` falls, `memReq` is high with `memAddr` = 0, even if a previous sequence was cut short.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restarts the fetch |
| memReq | output | 1 | Byte read request to boot memory |
| memAddr | output | 16 | Byte address of the current read |
| memAck | input | 1 | Read data valid; consumed only while `memReq` is high |
| memData | input | 64 | Read data bus; only bits [7:0] are used |
| masterWord | output | 32 | Configuration word of the local master |
| slaveWords | output | 224 | Seven slave configuration words, slave k at bits [32*(k-1) +: 32] |
| vectorBase | output | 32 | Exception vector base chosen by the prefix bit |
| resetVector | output | 32 | Reset exception vector address |
| done | output | 1 | One-cycle pulse when all words are complete |

## Verification
A byte is written into its word at the same rising edge that samples `memAck`. The address steps at that same edge. `done` rises one cycle later, and `vectorBase` follows the master word combinationally with no extra delay. The bench's memory model drives `memAck` and data on the falling edge, so each one is sampled by the next rising edge. The model checks `memAddr` at the moment it answers. The bench compares all word outputs on the falling edge where `done` is first seen high, and checks on the next falling edge that `done` and `memReq` are low. Stability after completion is checked over a stretch of cycles that includes stray acknowledges.

// File: rtl/cfgfetch_pkg.sv
package cfgfetch_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic take;   // capture current byte and step to next read
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_FIN   = 2'd1,
    ST_HOLD  = 2'd2
  } fetchState_t;

  localparam int VEC_W = 32;
endpackage

// File: rtl/cfgfetch_ctrl.sv
module cfgfetch_ctrl
  import cfgfetch_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       memAck,
  input  logic       lastIdx,
  output logic       memReq,
  output logic       done,
  output ctlStrobe_t strobe
);
  fetchState_t state, stateNxt;

  assign memReq      = (state == ST_FETCH);
  assign done        = (state == ST_FIN);
  assign strobe.take = memReq && memAck;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_FETCH: if (strobe.take && lastIdx) stateNxt = ST_FIN;
      ST_FIN:   stateNxt = ST_HOLD;
      ST_HOLD:  stateNxt = ST_HOLD;
      default:  stateNxt = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= stateNxt;
  end

  // R8: a pending request is not withdrawn before its acknowledge
  assert_req_held_R8: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memAck) |=> memReq);

  // R7: completion flag is a single-cycle pulse, no new reads follow (R1)
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !memReq));

  // R1: taking the final byte leads straight to completion
  assert_last_then_done_R1: assert property (@(posedge clk) disable iff (rst)
    (memReq && memAck && lastIdx) |=> done);
endmodule

// File: rtl/cfgfetch_dp.sv
module cfgfetch_dp
  import cfgfetch_pkg::*;
#(
  parameter int NUM_WORDS      = 8,
  parameter int BYTES_PER_WORD = 4,
  parameter int ADDR_STRIDE    = 8,
  parameter int ADDR_W         = 16,
  parameter int BUS_W          = 64,
  parameter int PREFIX_BIT     = 15,
  parameter logic [31:0] HIGH_BASE  = 32'hFFF0_0000,
  parameter logic [31:0] VEC_OFFSET = 32'h0000_0100,
  localparam int WORD_W        = 8 * BYTES_PER_WORD
)(
  input  logic                              clk,
  input  logic                              rst,
  input  ctlStrobe_t                        strobe,
  input  logic [BUS_W-1:0]                  memData,
  output logic [ADDR_W-1:0]                 memAddr,
  output logic                              lastIdx,
  output logic [WORD_W-1:0]                 masterWord,
  output logic [(NUM_WORDS-1)*WORD_W-1:0]   slaveWords,
  output logic [VEC_W-1:0]                  vectorBase,
  output logic [VEC_W-1:0]                  resetVector
);
  localparam int TOTAL   = NUM_WORDS * BYTES_PER_WORD;
  localparam int CNT_W   = $clog2(TOTAL + 1);
  localparam int BSEL_W  = $clog2(BYTES_PER_WORD);
  localparam int WSEL_W  = $clog2(NUM_WORDS);
  localparam int SHIFT   = $clog2(ADDR_STRIDE);
  localparam int PFX_LSB = WORD_W - 1 - PREFIX_BIT;

  logic [CNT_W-1:0]            readIdx;
  logic [WSEL_W-1:0]           wordSel;
  logic [BSEL_W-1:0]           byteSel;
  logic [7:0]                  laneByte;
  logic [NUM_WORDS*WORD_W-1:0] allWords;

  assign wordSel  = readIdx[BSEL_W +: WSEL_W];
  assign byteSel  = readIdx[BSEL_W-1:0];
  assign laneByte = memData[7:0];
  assign lastIdx  = (readIdx == CNT_W'(TOTAL - 1));
  assign memAddr  = ADDR_W'({readIdx, {SHIFT{1'b0}}});

  always_ff @(posedge clk) begin
    if (rst)              readIdx <= '0;
    else if (strobe.take) readIdx <= readIdx + 1'b1;
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] wq;
    always_ff @(posedge clk) begin
      if (rst) begin
        wq <= '0;
      end else if (strobe.take && wordSel == WSEL_W'(w)) begin
        for (int b = 0; b < BYTES_PER_WORD; b++)
          if (byteSel == BSEL_W'(b))
            wq[WORD_W-8-8*b +: 8] <= laneByte;
      end
    end
    assign allWords[w*WORD_W +: WORD_W] = wq;
  end

  assign masterWord  = allWords[WORD_W-1:0];
  assign slaveWords  = allWords[NUM_WORDS*WORD_W-1:WORD_W];
  assign vectorBase  = masterWord[PFX_LSB] ? HIGH_BASE : '0;
  assign resetVector = vectorBase + VEC_OFFSET;

  // R2: each consumed read moves the address up by one stride
  assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
    strobe.take |=> (memAddr == $past(memAddr) + ADDR_W'(ADDR_STRIDE)));

  // R8: address holds while no read is consumed
  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !strobe.take |=> $stable(memAddr));

  // R7: stored words only change on a consumed read
  assert_words_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !strobe.take |=> $stable(allWords));
endmodule

// File: rtl/boot_cfg_fetch.sv
module boot_cfg_fetch
  import cfgfetch_pkg::*;
#(
  parameter int NUM_WORDS      = 8,
  parameter int BYTES_PER_WORD = 4,
  parameter int ADDR_STRIDE    = 8,
  parameter int ADDR_W         = 16,
  parameter int BUS_W          = 64,
  parameter int PREFIX_BIT     = 15,
  localparam int WORD_W        = 8 * BYTES_PER_WORD
)(
  input  logic                            clk,
  input  logic                            rst,
  output logic                            memReq,
  output logic [ADDR_W-1:0]               memAddr,
  input  logic                            memAck,
  input  logic [BUS_W-1:0]                memData,
  output logic [WORD_W-1:0]               masterWord,
  output logic [(NUM_WORDS-1)*WORD_W-1:0] slaveWords,
  output logic [VEC_W-1:0]                vectorBase,
  output logic [VEC_W-1:0]                resetVector,
  output logic                            done
);
  ctlStrobe_t strobe;
  logic       lastIdx;

  cfgfetch_ctrl ctrl_i (
    .clk(clk), .rst(rst), .memAck(memAck), .lastIdx(lastIdx),
    .memReq(memReq), .done(done), .strobe(strobe)
  );

  cfgfetch_dp #(
    .NUM_WORDS(NUM_WORDS), .BYTES_PER_WORD(BYTES_PER_WORD),
    .ADDR_STRIDE(ADDR_STRIDE), .ADDR_W(ADDR_W), .BUS_W(BUS_W),
    .PREFIX_BIT(PREFIX_BIT)
  ) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .memData(memData),
    .memAddr(memAddr), .lastIdx(lastIdx), .masterWord(masterWord),
    .slaveWords(slaveWords), .vectorBase(vectorBase),
    .resetVector(resetVector)
  );
endmodule

// File: tb/boot_cfg_fetch_tb_top.sv
module boot_cfg_fetch_tb_top;
  localparam int PERIOD = 10;
  localparam int NCASE  = 4;
  // {master word, slave seed, ack latency}
  localparam logic [71:0] VEC [NCASE] = '{
    {32'h0001_0000, 32'h0BAD_F00D, 8'd0},
    {32'hFFFE_FFFF, 32'h1357_9BDF, 8'd1},
    {32'h1234_5678, 32'hCAFE_0001, 8'd3},
    {32'hA5A5_5A5A, 32'h0000_0000, 8'd5}
  };

  logic         clk = 0, rst = 1;
  logic         memReq, memAck, done;
  logic [15:0]  memAddr;
  logic [63:0]  memData;
  logic [31:0]  masterWord, vectorBase, resetVector;
  logic [223:0] slaveWords;

  int nChk = 0, nBad = 0;
  logic [31:0] curMaster, curSeed;
  int curLat = 0, rdCount = 0, waitCnt = 0;
  bit respOn = 0, spurAck = 0;

  always #(PERIOD/2) clk = ~clk;

  boot_cfg_fetch dut_i (
    .clk(clk), .rst(rst), .memReq(memReq), .memAddr(memAddr),
    .memAck(memAck), .memData(memData), .masterWord(masterWord),
    .slaveWords(slaveWords), .vectorBase(vectorBase),
    .resetVector(resetVector), .done(done)
  );

  function automatic logic [31:0] wordOf(int w);
    return (w == 0) ? curMaster : curSeed + 32'(w) * 32'h1020_3041;
  endfunction

  function automatic logic [7:0] byteAt(int idx);
    logic [31:0] wv = wordOf(idx / 4);
    return wv[31 - 8*(idx % 4) -: 8];
  endfunction

  task automatic chk(string req, logic [223:0] act, logic [223:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory model: answers at falling edges
  initial begin
    memAck = 0; memData = '0;
    forever begin
      @(negedge clk);
      if (rst) begin
        memAck = 0; rdCount = 0; waitCnt = 0;
      end else if (memAck) begin
        memAck = 0; waitCnt = 0;
      end else if (memReq && respOn) begin
        if (waitCnt >= curLat) begin
          chk("R2 addr", 224'(memAddr), 224'(rdCount * 8));
          memData = {{7{~byteAt(rdCount)}}, byteAt(rdCount)};  // R3 junk lanes
          memAck  = 1;
          rdCount++;
        end else waitCnt++;
      end else if (spurAck) begin
        memData = 64'hFFFF_FFFF_FFFF_FFFF;
        memAck  = 1;
      end
    end
  end

  task automatic doReset();
    respOn = 0; rst = 1;
    repeat (2) @(negedge clk);
    chk("R9 master clear", 224'(masterWord), '0);
    chk("R9 slave clear", slaveWords, '0);
    chk("R9 done clear", 224'(done), '0);
    rst = 0;
    @(negedge clk);
    chk("R9 restart req", 224'({memReq, memAddr}), 224'({1'b1, 16'h0}));
    respOn = 1;
  endtask

  task automatic waitDoneAndCheck();
    logic [223:0] expSlv;
    logic [31:0]  expBase;
    logic [223:0] snap;
    int guard = 0;
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    chk("R7 done seen", 224'(done), 224'(1));
    chk("R1 read count", 224'(rdCount), 224'(32));
    chk("R4 R5 master", 224'(masterWord), 224'(wordOf(0)));
    for (int k = 1; k < 8; k++) expSlv[32*(k-1) +: 32] = wordOf(k);
    chk("R4 R5 R3 slaves", slaveWords, expSlv);
    expBase = curMaster[16] ? 32'hFFF0_0000 : 32'h0;
    chk("R6 base", 224'(vectorBase), 224'(expBase));
    chk("R6 vector", 224'(resetVector), 224'(expBase + 32'h100));
    snap = {slaveWords[191:0], masterWord};
    @(negedge clk);
    chk("R7 done one cycle", 224'(done), '0);
    chk("R1 req low", 224'(memReq), '0);
    spurAck = 1;
    repeat (12) @(negedge clk);
    spurAck = 0;
    @(negedge clk);
    chk("R7 R8 words frozen", {slaveWords[191:0], masterWord}, snap);
    chk("R7 top slave frozen", 224'(slaveWords[223:192]), 224'(wordOf(7)));
    chk("R7 no new done", 224'({done, memReq}), '0);
  endtask

  initial begin
    #(PERIOD * 150000);
    nBad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCASE; i++) begin
      curMaster = VEC[i][71:40];
      curSeed   = VEC[i][39:8];
      curLat    = int'(VEC[i][7:0]);
      doReset();
      waitDoneAndCheck();
    end
    // R9: reset in the middle of a sequence restarts from address 0
    curMaster = 32'h7E01_00C3; curSeed = 32'h5555_AAAA; curLat = 2;
    doReset();
    while (rdCount < 10) @(negedge clk);
    chk("R8 partial progress", 224'(done), '0);
    doReset();
    waitDoneAndCheck();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule